// File: doc/BRIEF.md
# Correction Timing Pulse and Phase Counter

This block times the start of each frame and each line for the address generators that read the convergence-correction map and the overlay bitmap. The frame-start pulse follows the vertical-flyback-start pulse after a programmed number of regenerated horizontal sync falling edges. This places the correction map vertically. The line-start pulse follows each horizontal sync falling edge after a programmed number of pixel-rate clocks. This gives the user horizontal placement of overlays and correction data.

The block also measures, once per line, how many clocks pass from the horizontal sync falling edge to the rising edge of the horizontal flyback from deflection. It holds that count in a read-only register, which the system controller polls. All inputs are synchronous to the pixel-rate clock. The block samples the level inputs, and each edge counts from the clock at which the block sees it.

Top module: `cpt_corr_timing`

## Requirements
- R1: While reset is asserted and right after it, `frame_start` is 0, `line_start_n` is 1 and `phase_cnt` is 0.
- R2: Suppose `hsync_n` is first sampled low at clock edge K and `line_clks` holds D. Then `line_start_n` is low for exactly the one cycle after edge K+D.
- R3: With `line_clks` = 0, `line_start_n` goes low in the cycle right after the edge that samples the sync falling edge.
- R4: A new sync falling edge at or before the edge where a pending line-start would fire cancels that pulse. It also restarts the delay from the new edge.
- R5: `vfly_start` is a one-cycle high pulse. Suppose it is sampled at edge V and `frame_lines` holds L > 0. Then `frame_start` is high for exactly the one cycle after the edge that samples the L-th sync falling edge after V. A sync edge sampled at V itself is not counted.
- R6: With `frame_lines` = 0, `frame_start` is high in the cycle right after edge V.
- R7: Suppose a sync falling edge is sampled at edge S and the first later rising edge of `hflyback` is sampled at S+N. Then `phase_cnt` becomes N after that edge. Further flyback edges before the next sync are ignored, and `phase_cnt` changes at no other time except as R8 says.
- R8: If no flyback rising edge is sampled after S and before the next sync falling edge, `phase_cnt` becomes all ones at that sync edge. A count N above the register's maximum is stored as all ones. A flyback edge sampled at the same edge as a sync falling edge is ignored.
- R9: Each delay register is read only at its reference edge (sync falling edge for R2, `vfly_start` for R5). Changing it during a countdown does not move the pending pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Regenerated horizontal sync, active low |
| vfly_start | input | 1 | Vertical flyback start, one-cycle high pulse |
| hflyback | input | 1 | Horizontal flyback from deflection, active high |
| frame_lines | input | LINE_W | Sync edges to count before frame start |
| line_clks | input | PIX_W | Clocks to wait before line start |
| frame_start | output | 1 | One-cycle frame-start pulse, active high |
| line_start_n | output | 1 | One-cycle line-start pulse, active low |
| phase_cnt | output | PH_W | Latched sync-to-flyback phase count |

## Verification
A countdown register one step off shows up at once as a line-start or frame-start pulse one cycle early or late. A stuck armed flag shows up as a missing pulse or a duplicate pulse within one programmed delay. A wrong measurement state is visible by the next flyback or sync edge: `phase_cnt` takes a value other than the edge distance, misses all ones on a line without flyback, or changes on a second flyback edge. The scoreboard predicts the exact cycle of every pulse and every phase update, and it flags any output activity that was not predicted. Each fault is therefore caught at the first cycle where it becomes visible.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;

  // pulse decision: reference edge restarts, otherwise last tick of countdown fires
  function automatic logic fire_due(input logic ref_ev, input logic tick,
                                    input logic armed, input logic [31:0] cnt,
                                    input logic [31:0] dly);
    if (ref_ev) return (dly == 32'd0);
    return armed && tick && (cnt == 32'd1);
  endfunction

  // counter increment that sticks at its limit
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

endpackage

// File: rtl/cpt_edge_det.sv
module cpt_edge_det #(
  parameter cpt_pkg::edge_kind_e KIND = cpt_pkg::EDGE_FALL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  localparam logic IDLE = (KIND == cpt_pkg::EDGE_FALL);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= din;
  end

  generate
    if (KIND == cpt_pkg::EDGE_FALL) begin : g_fall
      assign edge_o = prev & ~din;
    end else begin : g_rise
      assign edge_o = ~prev & din;
    end
  endgenerate
endmodule

// File: rtl/cpt_pulse_delay.sv
module cpt_pulse_delay #(
  parameter int W          = 8,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ref_ev,
  input  logic         tick,
  input  logic [W-1:0] dly,
  output logic         pulse_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;
  logic         armed;
  logic         fire_now;
  logic         pulse_q;

  assign fire_now = cpt_pkg::fire_due(ref_ev, tick, armed, 32'(cnt), 32'(dly));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_now;
      if (ref_ev) begin
        cnt   <= dly;
        armed <= (dly != '0);
      end else if (armed && tick) begin
        cnt <= cnt - ONE;
        if (cnt == ONE) armed <= 1'b0;
      end
    end
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign pulse_o = ~pulse_q;
    end else begin : g_high
      assign pulse_o = pulse_q;
    end
  endgenerate
endmodule

// File: rtl/cpt_phase_meter.sv
module cpt_phase_meter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_ev,
  input  logic         stop_ev,
  output logic [W-1:0] phase_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt;
  logic         busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      busy    <= 1'b0;
      phase_o <= '0;
    end else if (start_ev) begin
      if (busy) phase_o <= MAXV;
      cnt  <= W'(1);
      busy <= 1'b1;
    end else if (busy && stop_ev) begin
      phase_o <= cnt;
      busy    <= 1'b0;
    end else if (busy) begin
      cnt <= W'(cpt_pkg::sat_inc(32'(cnt), 32'(MAXV)));
    end
  end
endmodule

// File: rtl/cpt_corr_timing.sv
module cpt_corr_timing #(
  parameter int LINE_W = 11,
  parameter int PIX_W  = 12,
  parameter int PH_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_n,
  input  logic              vfly_start,
  input  logic              hflyback,
  input  logic [LINE_W-1:0] frame_lines,
  input  logic [PIX_W-1:0]  line_clks,
  output logic              frame_start,
  output logic              line_start_n,
  output logic [PH_W-1:0]   phase_cnt
);
  logic hs_fall;
  logic fly_rise;

  cpt_edge_det #(.KIND(cpt_pkg::EDGE_FALL)) u_hs_edge (
    .clk(clk), .rst_n(rst_n), .din(hsync_n), .edge_o(hs_fall));

  cpt_edge_det #(.KIND(cpt_pkg::EDGE_RISE)) u_fly_edge (
    .clk(clk), .rst_n(rst_n), .din(hflyback), .edge_o(fly_rise));

  cpt_pulse_delay #(.W(PIX_W), .ACTIVE_LOW(1'b1)) u_line_dly (
    .clk(clk), .rst_n(rst_n), .ref_ev(hs_fall), .tick(1'b1),
    .dly(line_clks), .pulse_o(line_start_n));

  cpt_pulse_delay #(.W(LINE_W), .ACTIVE_LOW(1'b0)) u_frame_dly (
    .clk(clk), .rst_n(rst_n), .ref_ev(vfly_start), .tick(hs_fall),
    .dly(frame_lines), .pulse_o(frame_start));

  cpt_phase_meter #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .start_ev(hs_fall), .stop_ev(fly_rise),
    .phase_o(phase_cnt));
endmodule

// File: rtl/cpt_corr_timing_chk.sv
module cpt_corr_timing_chk #(
  parameter int LINE_W = 11,
  parameter int PIX_W  = 12,
  parameter int PH_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hs_fall,
  input logic              fly_rise,
  input logic              vfly_start,
  input logic [LINE_W-1:0] frame_lines,
  input logic [PIX_W-1:0]  line_clks,
  input logic              frame_start,
  input logic              line_start_n,
  input logic [PH_W-1:0]   phase_cnt
);
  assert_line_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fall && line_clks == '0) |=> !line_start_n);

  assert_frame_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vfly_start && frame_lines == '0) |=> frame_start);

  assert_frame_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(vfly_start || hs_fall));

  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_fall && !fly_rise) |=> $stable(phase_cnt));

  assert_phase_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fall |=> ($stable(phase_cnt) || phase_cnt == '1));
endmodule

bind cpt_corr_timing cpt_corr_timing_chk #(
  .LINE_W(LINE_W), .PIX_W(PIX_W), .PH_W(PH_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hs_fall(hs_fall), .fly_rise(fly_rise),
  .vfly_start(vfly_start), .frame_lines(frame_lines), .line_clks(line_clks),
  .frame_start(frame_start), .line_start_n(line_start_n), .phase_cnt(phase_cnt)
);

// File: tb/cpt_corr_timing_tb_top.sv
module cpt_corr_timing_tb_top;
  localparam int LINE_W = 8;
  localparam int PIX_W  = 8;
  localparam int PH_W   = 6;
  localparam int PMAX   = (1 << PH_W) - 1;

  typedef struct {int cyc; int val; string req;} exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_n = 1'b1, vfly_start = 1'b0, hflyback = 1'b0;
  logic [LINE_W-1:0] frame_lines = '0;
  logic [PIX_W-1:0]  line_clks = '0;
  logic frame_start, line_start_n;
  logic [PH_W-1:0] phase_cnt;

  int cyc = 0, checks = 0, errors = 0;
  bit run = 1'b0;
  string cur_req = "R2";
  exp_t lq[$], fq[$], pq[$];
  bit fpend = 0; int fref = 0, frem = 0;
  bit pmeas = 0; int pstart = 0;
  int last_phase = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpt_corr_timing #(.LINE_W(LINE_W), .PIX_W(PIX_W), .PH_W(PH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vfly_start(vfly_start),
    .hflyback(hflyback), .frame_lines(frame_lines), .line_clks(line_clks),
    .frame_start(frame_start), .line_start_n(line_start_n), .phase_cnt(phase_cnt));

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // scoreboard driver side: predict from requirements
  task automatic book_vf(int k);
    fpend = 0;
    if (frame_lines == 0) fq.push_back('{k, 1, cur_req});
    else begin fpend = 1; fref = k; frem = int'(frame_lines); end
  endtask

  task automatic book_hs(int k);
    while (lq.size() > 0 && lq[$].cyc >= k) void'(lq.pop_back());   // R4 cancel
    lq.push_back('{k + int'(line_clks), 0, cur_req});
    if (fpend && k > fref) begin
      frem--;
      if (frem == 0) begin fq.push_back('{k, 1, cur_req}); fpend = 0; end
    end
    if (pmeas) pq.push_back('{k, PMAX, cur_req});
    pmeas = 1; pstart = k;
  endtask

  task automatic book_fl(int k);
    if (pmeas && k > pstart) begin
      pq.push_back('{k, ((k - pstart) > PMAX) ? PMAX : (k - pstart), cur_req});
      pmeas = 0;
    end
  endtask

  task automatic edge_ev(bit hs, bit fl, bit vf);
    int k = cyc + 1;
    if (vf) book_vf(k);
    if (hs) book_hs(k);
    if (fl) book_fl(k);
    hsync_n = !hs; hflyback = fl; vfly_start = vf;
    step(1);
    hsync_n = 1'b1; hflyback = 1'b0; vfly_start = 1'b0;
  endtask

  // scoreboard monitor side
  always @(negedge clk) if (run) begin
    if (lq.size() > 0 && lq[0].cyc == cyc) begin
      chk(line_start_n == 1'b0, lq[0].req, "line_start_n", int'(line_start_n), 0);
      void'(lq.pop_front());
    end else if (line_start_n == 1'b0)
      chk(1'b0, "R2", "unexpected line_start_n", 0, 1);
    if (fq.size() > 0 && fq[0].cyc == cyc) begin
      chk(frame_start == 1'b1, fq[0].req, "frame_start", int'(frame_start), 1);
      void'(fq.pop_front());
    end else if (frame_start)
      chk(1'b0, "R5", "unexpected frame_start", 1, 0);
    if (pq.size() > 0 && pq[0].cyc == cyc) begin
      chk(int'(phase_cnt) == pq[0].val, pq[0].req, "phase_cnt", int'(phase_cnt), pq[0].val);
      last_phase = pq[0].val;
      void'(pq.pop_front());
    end else if (int'(phase_cnt) != last_phase)
      chk(1'b0, "R7", "phase_cnt changed", int'(phase_cnt), last_phase);
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(4);
    @(negedge clk);
    chk(frame_start == 1'b0, "R1", "frame_start in reset", int'(frame_start), 0);
    chk(line_start_n == 1'b1, "R1", "line_start_n in reset", int'(line_start_n), 1);
    chk(phase_cnt == '0, "R1", "phase_cnt in reset", int'(phase_cnt), 0);
    @(posedge clk); #1;
    rst_n = 1'b1; run = 1'b1;
    step(3);
    chk(line_start_n == 1'b1 && frame_start == 1'b0, "R1", "idle after reset", 0, 0);

    cur_req = "R3"; line_clks = 0; edge_ev(1, 0, 0); step(8);
    cur_req = "R2";
    for (int d = 1; d < 20; d += 6) begin line_clks = PIX_W'(d); edge_ev(1, 0, 0); step(d + 5); end
    cur_req = "R9"; line_clks = 8; edge_ev(1, 0, 0); step(3); line_clks = 2; step(12);
    cur_req = "R4"; line_clks = 10; edge_ev(1, 0, 0); step(4); edge_ev(1, 0, 0); step(15);
    line_clks = 6; edge_ev(1, 0, 0); step(5); edge_ev(1, 0, 0); step(10);

    cur_req = "R7"; line_clks = 3; edge_ev(1, 0, 0); step(6); edge_ev(0, 1, 0); step(3);
    edge_ev(0, 1, 0); step(4);
    edge_ev(1, 0, 0); step(1); edge_ev(0, 1, 0); step(5);
    cur_req = "R8"; edge_ev(1, 0, 0); step(10); edge_ev(1, 0, 0); step(3); edge_ev(0, 1, 0); step(3);
    edge_ev(1, 0, 0); step(70); edge_ev(0, 1, 0); step(3);
    edge_ev(1, 1, 0); step(4); edge_ev(0, 1, 0); step(3);

    cur_req = "R5"; line_clks = 40; frame_lines = 3; edge_ev(0, 0, 1); step(2);
    repeat (4) begin edge_ev(1, 0, 0); step(5); end
    frame_lines = 2; edge_ev(1, 0, 1); step(3);
    repeat (3) begin edge_ev(1, 0, 0); step(3); end
    cur_req = "R6"; frame_lines = 0; edge_ev(0, 0, 1); step(5);
    cur_req = "R9"; frame_lines = 4; edge_ev(0, 0, 1); step(1); frame_lines = 1;
    repeat (5) begin edge_ev(1, 0, 0); step(4); end
    step(60);

    chk((lq.size() + fq.size() + pq.size()) == 0, "R2", "predicted events left",
        lq.size() + fq.size() + pq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule